// File: doc/BRIEF.md
# Video Compare Predicate Set

This block is the compare-and-predicate-set stage of one lane of a shader datapath. Each accepted request names two source words. From each it takes a sub-word operand: one selected byte, the low half, the high half, or nothing at all (zero). The B operand may instead come from a 16-bit immediate. The two operands are compared under a three-bit condition code. The compare outcome is then merged with a source predicate through a selectable boolean operator.

Two predicate results come out of one compare. The primary result uses the true outcome and the secondary result uses the inverted outcome. Both merge with the same source predicate and land in a local 8-entry predicate file. The top index of that file is a constant-true predicate, which also serves as the "no destination" code for the secondary write. A request whose primary destination is that constant index is rejected and flagged.

The request interface is valid/ready. `in_ready` is held high at all times, so the unit never applies back-pressure: every cycle with `in_valid` high is one accepted request. The whole predicate file is visible on `pred_bits`. A request's writes appear there one clock edge after the cycle in which it was accepted.

Top module: `vcp_unit`

## Requirements
- R1: While reset is asserted and right after it, `pred_bits` equals 8'h80 (only the constant index 7 reads 1) and `err_const_dst` is 0.
- R2: Operand select codes are 0 = byte number `*_byte` (bits 8k+7..8k), 1 = bits 15..0, 2 = bits 31..16, 3 = zero. The selected field is sign-extended when its signed flag is 1 and zero-extended otherwise.
- R3: When `b_use_imm` is 1, operand B is `b_imm`, sign-extended if `b_signed` is 1 and zero-extended otherwise. `b_word`, `b_sel` and `b_byte` are then ignored.
- R4: The compare is signed if `a_signed` or `b_signed` is 1, and unsigned only when both are 0.
- R5: `cond` bit 0 enables "less than", bit 1 enables "equal" and bit 2 enables "greater than". The outcome is the OR of the enabled relations that hold, giving 0 never, 1 LT, 2 EQ, 3 LE, 4 GT, 5 NE, 6 GE, 7 always.
- R6: `comb_op` is 0 AND, 1 OR, 2 XOR, 3 XNOR. The source predicate is file entry `src_idx` as it stands in the cycle the request is accepted, and index 7 reads 1.
- R7: For an accepted request with `dst_p_idx` not 7, entry `dst_p_idx` takes (outcome OP source) at the next clock edge.
- R8: At that same edge, if `dst_s_idx` is not 7, entry `dst_s_idx` takes ((NOT outcome) OP source). When both indices are equal, the secondary value is the one stored.
- R9: An accepted request with `dst_p_idx` equal to 7 writes no entry, and `err_const_dst` is 1 for exactly the following cycle.
- R10: In a cycle without `in_valid`, no entry changes and `err_const_dst` is 0 in the next cycle.
- R11: `in_ready` is 1 in every cycle after reset, and every `in_valid` cycle is a separate accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted (always 1) |
| a_word | input | 32 | Source word for operand A |
| a_sel | input | 2 | Operand A field select |
| a_byte | input | 2 | Byte number for A when field select is 0 |
| a_signed | input | 1 | Operand A is signed |
| b_word | input | 32 | Source word for operand B |
| b_imm | input | 16 | Immediate for operand B |
| b_use_imm | input | 1 | Take B from the immediate |
| b_sel | input | 2 | Operand B field select |
| b_byte | input | 2 | Byte number for B when field select is 0 |
| b_signed | input | 1 | Operand B is signed |
| cond | input | 3 | Condition code |
| comb_op | input | 2 | Boolean combiner select |
| src_idx | input | 3 | Source predicate index |
| dst_p_idx | input | 3 | Primary destination index |
| dst_s_idx | input | 3 | Secondary destination index (7 = none) |
| err_const_dst | output | 1 | Rejected write to the constant predicate |
| pred_bits | output | 8 | Contents of the predicate file |

## Verification
The assertions assume that the request fields are stable and defined whenever `in_valid` is high. They also assume `in_valid` is low during reset, so a predicate-file change is always traced to one request in the cycle before it. The bench drives every request field on the falling edge and holds it through the rising edge. It drops `in_valid` during reset and in the idle stretch, and it draws destination indices from the full range, 7 included, so the rejection and no-secondary paths are reached.

// File: rtl/vcp_pkg.sv
package vcp_pkg;

  typedef enum logic [1:0] {
    SEL_BYTE    = 2'd0,
    SEL_HALF_LO = 2'd1,
    SEL_HALF_HI = 2'd2,
    SEL_NONE    = 2'd3
  } sub_sel_e;

  typedef enum logic [1:0] {
    CMB_AND  = 2'd0,
    CMB_OR   = 2'd1,
    CMB_XOR  = 2'd2,
    CMB_XNOR = 2'd3
  } comb_e;

  // Relation enable bits inside the condition code.
  localparam int CC_LT_BIT = 0;
  localparam int CC_EQ_BIT = 1;
  localparam int CC_GT_BIT = 2;

  function automatic logic combine(comb_e op, logic x, logic y);
    logic r;
    unique case (op)
      CMB_AND:  r = x & y;
      CMB_OR:   r = x | y;
      CMB_XOR:  r = x ^ y;
      CMB_XNOR: r = ~(x ^ y);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/vcp_operand_extract.sv
module vcp_operand_extract
  import vcp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int NBYTES = DATA_W / 8,
  localparam int BSEL_W = $clog2(NBYTES),
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] word,
  input  logic [1:0]        sel,
  input  logic [BSEL_W-1:0] byte_pos,
  input  logic              is_signed,
  input  logic              use_imm,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] value
);

  logic [7:0] lane [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign lane[g] = word[g*8 +: 8];
  end

  logic [7:0]        pick_b;
  logic [HALF_W-1:0] pick_h;

  always_comb begin
    pick_b = lane[byte_pos];
    pick_h = '0;
    value  = '0;
    if (use_imm) begin
      value = {{(DATA_W-IMM_W){is_signed & imm[IMM_W-1]}}, imm};
    end else begin
      unique case (sub_sel_e'(sel))
        SEL_BYTE: begin
          value = {{(DATA_W-8){is_signed & pick_b[7]}}, pick_b};
        end
        SEL_HALF_LO: begin
          pick_h = word[HALF_W-1:0];
          value  = {{(DATA_W-HALF_W){is_signed & pick_h[HALF_W-1]}}, pick_h};
        end
        SEL_HALF_HI: begin
          pick_h = word[DATA_W-1:HALF_W];
          value  = {{(DATA_W-HALF_W){is_signed & pick_h[HALF_W-1]}}, pick_h};
        end
        SEL_NONE: begin
          value = '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/vcp_compare.sv
module vcp_compare
  import vcp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              signed_cmp,
  input  logic [2:0]        cond,
  output logic              hit
);

  logic lt, eq, gt;

  always_comb begin
    eq = (op_a == op_b);
    if (signed_cmp) lt = ($signed(op_a) < $signed(op_b));
    else            lt = (op_a < op_b);
    gt  = ~lt & ~eq;
    hit = (cond[CC_LT_BIT] & lt) | (cond[CC_EQ_BIT] & eq) | (cond[CC_GT_BIT] & gt);
  end

endmodule

// File: rtl/vcp_pred_file.sv
module vcp_pred_file #(
  parameter int PRED_N = 8,
  localparam int IDX_W = $clog2(PRED_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_bit,
  input  logic              we_p,
  input  logic [IDX_W-1:0]  wp_idx,
  input  logic              wp_bit,
  input  logic              we_s,
  input  logic [IDX_W-1:0]  ws_idx,
  input  logic              ws_bit,
  output logic [PRED_N-1:0] bits
);

  for (genvar g = 0; g < PRED_N; g++) begin : g_entry
    if (g == PRED_N - 1) begin : g_const
      assign bits[g] = 1'b1;
    end else begin : g_reg
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n)                                q <= 1'b0;
        else if (we_s && ws_idx == IDX_W'(g))      q <= ws_bit;
        else if (we_p && wp_idx == IDX_W'(g))      q <= wp_bit;
      end
      assign bits[g] = q;
    end
  end

  assign rd_bit = bits[rd_idx];

endmodule

// File: rtl/vcp_unit.sv
module vcp_unit
  import vcp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int PRED_N = 8,
  localparam int IDX_W  = $clog2(PRED_N),
  localparam int BSEL_W = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] a_word,
  input  logic [1:0]        a_sel,
  input  logic [BSEL_W-1:0] a_byte,
  input  logic              a_signed,
  input  logic [DATA_W-1:0] b_word,
  input  logic [IMM_W-1:0]  b_imm,
  input  logic              b_use_imm,
  input  logic [1:0]        b_sel,
  input  logic [BSEL_W-1:0] b_byte,
  input  logic              b_signed,
  input  logic [2:0]        cond,
  input  logic [1:0]        comb_op,
  input  logic [IDX_W-1:0]  src_idx,
  input  logic [IDX_W-1:0]  dst_p_idx,
  input  logic [IDX_W-1:0]  dst_s_idx,
  output logic              err_const_dst,
  output logic [PRED_N-1:0] pred_bits
);

  localparam logic [IDX_W-1:0] CONST_IDX = IDX_W'(PRED_N - 1);

  logic [DATA_W-1:0] opa, opb;
  logic              hit, src_bit;
  logic              pri_bit, sec_bit;
  logic              accept, bad_dst;
  logic              we_p, we_s;

  assign in_ready = 1'b1;
  assign accept   = in_valid & in_ready;
  assign bad_dst  = (dst_p_idx == CONST_IDX);

  vcp_operand_extract #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext_a (
    .word(a_word), .sel(a_sel), .byte_pos(a_byte), .is_signed(a_signed),
    .use_imm(1'b0), .imm('0), .value(opa)
  );

  vcp_operand_extract #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext_b (
    .word(b_word), .sel(b_sel), .byte_pos(b_byte), .is_signed(b_signed),
    .use_imm(b_use_imm), .imm(b_imm), .value(opb)
  );

  vcp_compare #(.DATA_W(DATA_W)) u_cmp (
    .op_a(opa), .op_b(opb), .signed_cmp(a_signed | b_signed),
    .cond(cond), .hit(hit)
  );

  always_comb begin
    pri_bit = combine(comb_e'(comb_op), hit, src_bit);
    sec_bit = combine(comb_e'(comb_op), ~hit, src_bit);
  end

  assign we_p = accept & ~bad_dst;
  assign we_s = accept & ~bad_dst & (dst_s_idx != CONST_IDX);

  vcp_pred_file #(.PRED_N(PRED_N)) u_pf (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(src_idx), .rd_bit(src_bit),
    .we_p(we_p), .wp_idx(dst_p_idx), .wp_bit(pri_bit),
    .we_s(we_s), .ws_idx(dst_s_idx), .ws_bit(sec_bit),
    .bits(pred_bits)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_const_dst <= 1'b0;
    else        err_const_dst <= accept & bad_dst;
  end

endmodule

// File: rtl/vcp_unit_checker.sv
module vcp_unit_checker #(
  parameter int PRED_N = 8,
  localparam int IDX_W = $clog2(PRED_N)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        cond,
  input logic [1:0]        comb_op,
  input logic [IDX_W-1:0]  dst_p_idx,
  input logic [IDX_W-1:0]  dst_s_idx,
  input logic              err_const_dst,
  input logic [PRED_N-1:0] pred_bits
);

  localparam logic [IDX_W-1:0]  CIDX = IDX_W'(PRED_N - 1);
  localparam logic [PRED_N-1:0] ONE  = PRED_N'(1);

  a_r11_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);

  a_r9_flag_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dst_p_idx == CIDX) |=> err_const_dst);

  a_r9_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dst_p_idx == CIDX) |=> $stable(pred_bits));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(pred_bits) && !err_const_dst));

  a_r7_only_primary: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dst_p_idx != CIDX && dst_s_idx == CIDX) |=>
      (((pred_bits ^ $past(pred_bits)) & ~(ONE << $past(dst_p_idx))) == '0));

  a_r5_never_and: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond == 3'd0 && comb_op == 2'd0 && dst_p_idx != CIDX && dst_s_idx == CIDX)
      |=> (pred_bits[$past(dst_p_idx)] == 1'b0));

  a_r5_always_or: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond == 3'd7 && comb_op == 2'd1 && dst_p_idx != CIDX && dst_s_idx == CIDX)
      |=> (pred_bits[$past(dst_p_idx)] == 1'b1));

endmodule

bind vcp_unit vcp_unit_checker #(.PRED_N(PRED_N)) u_vcp_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .cond(cond), .comb_op(comb_op), .dst_p_idx(dst_p_idx), .dst_s_idx(dst_s_idx),
  .err_const_dst(err_const_dst), .pred_bits(pred_bits)
);

// File: tb/vcp_unit_bench.sv
module vcp_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] a_word = '0, b_word = '0;
  logic [1:0]  a_sel = '0, b_sel = '0, a_byte = '0, b_byte = '0, comb_op = '0;
  logic        a_signed = 1'b0, b_signed = 1'b0, b_use_imm = 1'b0;
  logic [15:0] b_imm = '0;
  logic [2:0]  cond = '0, src_idx = '0, dst_p_idx = '0, dst_s_idx = 3'd7;
  logic        err_const_dst;
  logic [7:0]  pred_bits;

  int nchk = 0, nerr = 0;
  bit done = 0;

  typedef struct { logic [7:0] bits; logic err; string tag; } exp_t;
  exp_t q[$];
  bit pm[8];

  always #5 clk = ~clk;

  vcp_unit u_vcp_unit (.*);

  task automatic check(bit ok, string tag, longint act, longint expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic longint field(logic [31:0] w, int sel, int pos, bit sg);
    longint v;
    case (sel)
      0: begin v = (w >> (8*pos)) & 32'hFF;  if (sg && v >= 128)   v -= 256;   end
      1: begin v = w & 32'hFFFF;             if (sg && v >= 32768) v -= 65536; end
      2: begin v = (w >> 16) & 32'hFFFF;     if (sg && v >= 32768) v -= 65536; end
      default: v = 0;
    endcase
    return v;
  endfunction

  function automatic bit comb(int op, bit x, bit y);
    case (op)
      0: return x && y;
      1: return x || y;
      2: return x != y;
      default: return x == y;
    endcase
  endfunction

  function automatic logic [7:0] model_bits();
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = pm[i];
    return r;
  endfunction

  task automatic do_op(logic [31:0] aw, int asel, int ab, bit asg,
                       logic [31:0] bw, int bsel, int bb, bit bsg, bit uimm, logic [15:0] imm,
                       int cc, int op, int src, int dp, int ds, string tag);
    longint va, vb;
    bit lt, eq, gt, res, sp;
    exp_t e;
    @(negedge clk);
    a_word = aw; a_sel = 2'(asel); a_byte = 2'(ab); a_signed = asg;
    b_word = bw; b_sel = 2'(bsel); b_byte = 2'(bb); b_signed = bsg;
    b_use_imm = uimm; b_imm = imm; cond = 3'(cc); comb_op = 2'(op);
    src_idx = 3'(src); dst_p_idx = 3'(dp); dst_s_idx = 3'(ds); in_valid = 1'b1;
    va = field(aw, asel, ab, asg);
    vb = uimm ? field({16'h0, imm}, 1, 0, bsg) : field(bw, bsel, bb, bsg);
    if (!asg && !bsg) begin va = va & 32'hFFFFFFFF; vb = vb & 32'hFFFFFFFF; end
    lt = va < vb; eq = va == vb; gt = va > vb;
    res = (cc[0] && lt) || (cc[1] && eq) || (cc[2] && gt);
    sp = pm[src];
    e.err = (dp == 7);
    if (dp != 7) begin
      pm[dp] = comb(op, res, sp);
      if (ds != 7) pm[ds] = comb(op, !res, sp);
    end
    e.bits = model_bits();
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares each accepted request's effect after the edge.
  always @(posedge clk) begin
    if (rst_n && in_valid) begin
      exp_t e;
      check(in_ready === 1'b1, "R11 ready", in_ready, 1);
      #2;
      if (q.size() == 0) check(0, "R11 queue empty", 0, 1);
      else begin
        e = q.pop_front();
        check(pred_bits === e.bits, e.tag, pred_bits, e.bits);
        check(err_const_dst === e.err, {e.tag, " err"}, err_const_dst, e.err);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) pm[i] = (i == 7);
    repeat (3) @(negedge clk);
    check(pred_bits === 8'h80, "R1 reset bits", pred_bits, 8'h80);
    check(err_const_dst === 1'b0, "R1 reset err", err_const_dst, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pred_bits === 8'h80, "R1 after reset", pred_bits, 8'h80);

    // R2 R4: signed byte 2 (-16) vs unsigned immediate 5, LT
    do_op(32'h00F00000, 0, 2, 1, 32'h0, 0, 0, 0, 1, 16'd5, 1, 0, 7, 0, 1, "R2 signed byte LT");
    // R2: high half vs low half, EQ, OR with p0
    do_op(32'h12340000, 2, 0, 0, 32'h00001234, 1, 0, 0, 0, 16'h0, 2, 1, 0, 2, 3, "R2 half EQ");
    // R4: unsigned 200 vs signed -1 -> signed compare, GT
    do_op(32'h000000C8, 0, 0, 0, 32'hFFFFFFFF, 0, 0, 1, 0, 16'h0, 4, 0, 7, 4, 7, "R4 mixed sign GT");
    // R4: both unsigned, 0xFF vs 0x01 bytes
    do_op(32'h0000FF00, 0, 1, 0, 32'h01000000, 0, 3, 0, 0, 16'h0, 4, 0, 7, 5, 6, "R4 unsigned GT");
    // R3: signed immediate -1 vs 0, GE, XOR
    do_op(32'h00000000, 1, 0, 0, 32'h0, 0, 0, 1, 1, 16'hFFFF, 6, 2, 4, 5, 6, "R3 signed imm");
    // R3: unsigned immediate 0xFFFF, b_word ignored
    do_op(32'h0000FFFF, 1, 0, 0, 32'h12345678, 2, 1, 0, 1, 16'hFFFF, 2, 0, 7, 1, 7, "R3 unsigned imm");
    // R2: select 3 is zero, XNOR
    do_op(32'hFFFFFFFF, 3, 0, 1, 32'h0, 0, 0, 0, 1, 16'h0, 2, 3, 1, 3, 0, "R2 zero select");
    // R9: constant destination
    do_op(32'h1, 1, 0, 0, 32'h1, 1, 0, 0, 0, 16'h0, 7, 1, 7, 7, 0, "R9 const dest");
    // R8: same index for both writes
    do_op(32'h5, 1, 0, 0, 32'h5, 1, 0, 0, 0, 16'h0, 2, 0, 7, 2, 2, "R8 same index");
    // R6: source predicate read before write, same index as dest
    do_op(32'h1, 1, 0, 0, 32'h2, 1, 0, 0, 0, 16'h0, 1, 2, 4, 4, 7, "R6 src before write");
    // R5: every condition on LT, EQ and GT pairs
    for (int cc = 0; cc < 8; cc++) begin
      do_op(32'h3, 1, 0, 0, 32'h7, 1, 0, 0, 0, 16'h0, cc, 0, 7, 0, 1, $sformatf("R5 cc%0d lt", cc));
      do_op(32'h7, 1, 0, 0, 32'h7, 1, 0, 0, 0, 16'h0, cc, 0, 7, 2, 3, $sformatf("R5 cc%0d eq", cc));
      do_op(32'h9, 1, 0, 0, 32'h7, 1, 0, 0, 0, 16'h0, cc, 0, 7, 4, 5, $sformatf("R5 cc%0d gt", cc));
    end
    // R6: each combiner with source 0 and 1
    for (int op = 0; op < 4; op++) begin
      do_op(32'h1, 1, 0, 0, 32'h1, 1, 0, 0, 0, 16'h0, 2, op, 7, 6, 7, $sformatf("R6 op%0d src1", op));
      do_op(32'h1, 1, 0, 0, 32'h1, 1, 0, 0, 0, 16'h0, 2, op, 1, 3, 5, $sformatf("R6 op%0d src", op));
    end
    // R10: idle cycles change nothing
    @(negedge clk);
    in_valid = 1'b0;
    begin
      logic [7:0] snap;
      snap = model_bits();
      repeat (3) @(negedge clk);
      check(pred_bits === snap, "R10 idle bits", pred_bits, snap);
      check(err_const_dst === 1'b0, "R10 idle err", err_const_dst, 0);
    end
    // R7 R8: mixed random requests, back to back
    for (int n = 0; n < 300; n++) begin
      do_op($urandom, $urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom),
            $urandom, $urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom),
            1'($urandom), 16'($urandom), $urandom_range(0, 7), $urandom_range(0, 3),
            $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7), "R7 random");
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R11 all consumed", q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule